// File: doc/BRIEF.md
# Successive-Approximation Conversion and Calibration Sequencer

This block is the digital control half of a 16-bit successive-approximation converter. It watches a sampling strobe, an externally supplied conversion clock and an asynchronous calibration request. All of them are oversampled by a faster system clock. It drives a trial code, in offset binary, to the capacitor DAC and reads back a single comparator decision. Each finished conversion is placed in a parallel result latch in two's complement form. A status line stays high while a conversion or a calibration is running.

A conversion is committed when the sampling strobe falls. Conversion-clock edges inside a short settling window after that fall are discarded. The next 17 rising edges resolve the code, most significant bit first, and publish it. A calibration request aborts whatever is running and clears the block. The calibration run starts when the request is released and lasts a fixed number of conversion-clock edges. The block then owes one more clock edge, which it takes from the next conversion if none arrives before it. Measuring and correcting capacitor mismatch is outside this block, and calibration is modelled as an edge count.

Top module: `sar_seq_top`

## Requirements
- R1: A falling `sample_i` while idle commits a conversion. `busy_o` is low 1 system clock after the fall and high no later than 4 system clocks after it.
- R2: The trial code starts at 0x8000 in offset binary. On each rising conversion-clock edge one bit, MSB first, is kept when `cmp_hi_i` is 0 and cleared when it is 1, and the next lower bit is then set.
- R3: Rising conversion-clock edges during the first `SETTLE_CYCLES` system clocks after the commit are discarded. They neither advance the count nor change the trial code.
- R4: `busy_o` falls on the 17th counted rising edge, in the same cycle that `result_o` takes the new code. Later conversion-clock edges change neither `busy_o` nor `result_o`.
- R5: `result_o` keeps the previous code throughout a conversion until that conversion's 17th edge.
- R6: Rising or falling `sample_i` while `busy_o` is high has no effect on the running conversion, and it does not start another one.
- R7: If `sample_i` is high when `busy_o` falls, its next falling edge commits a new conversion at once (back-to-back operation).
- R8: Raising `cal_i` forces `busy_o` high and clears `result_o` to 0 with no clock edge. It aborts a conversion in progress, so that conversion never updates `result_o`.
- R9: After `cal_i` falls, calibration counts `CAL_CYCLES` rising conversion-clock edges, after which `busy_o` falls.
- R10: After calibration one extra rising edge is owed. If it does not arrive while idle, the next conversion absorbs its first counted edge and finishes on the 18th.
- R11: During calibration with `sample_i` high, `result_o[1:0]` shows the number of conversion-clock edges since `cal_i` fell, modulo 4. The upper bits show the cleared latch (0).
- R12: `result_o` is the two's complement code (MSB of the final trial inverted). An input above full scale gives 0x7FFF, and one below negative full scale gives 0x8000.
- R13: After `rst_n` is released, `busy_o`, `result_o` and `trial_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the conversion clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| cnv_clk_i | input | 1 | Conversion clock (asynchronous) |
| sample_i | input | 1 | Sampling strobe; the falling edge commits a conversion |
| cal_i | input | 1 | Asynchronous calibration request, active high |
| cmp_hi_i | input | 1 | Comparator decision: 1 means the trial is above the input |
| trial_o | output | W | Offset-binary trial code to the DAC |
| busy_o | output | 1 | High while converting or calibrating |
| result_o | output | W | Two's complement result latch |

## Verification
A wrong edge count in this block shows first at `busy_o`. The status line falls one conversion-clock edge early or late. This is caught by checking it high after 16 counted edges and low after the 17th. A trial register that keeps or clears the wrong bit shows up only at the end of the conversion, as a wrong code on `result_o`. Input values are therefore chosen to exercise every bit pattern and both clamps. A lost or doubled calibration tail edge, or a lost settling window, moves the end of the next conversion by one edge. The same busy-edge check catches it within that conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_CONV    = 3'd2,
    ST_CALHOLD = 3'd3,
    ST_CAL     = 3'd4
  } seq_state_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES    = 2,
  parameter bit ASYNC_SET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic d_i,
  output logic lvl_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (ASYNC_SET) begin : g_aset
      always_ff @(posedge clk or negedge rst_n or posedge set_i) begin
        if (!rst_n)     chain_q <= '0;
        else if (set_i) chain_q <= '1;
        else            chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chain_q <= '0;
        else if (set_i) chain_q <= '1;
        else            chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         too_high_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] code_o
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  // Decide the bit under test, then raise the next lower trial bit.
  function automatic logic [W-1:0] resolve_bit(input logic [W-1:0] trial,
                                               input logic [W-1:0] mask,
                                               input logic         too_high);
    logic [W-1:0] r;
    r = too_high ? (trial & ~mask) : trial;
    r = r | (mask >> 1);
    return r;
  endfunction

  // Offset binary to two's complement: invert the sign position.
  function automatic logic [W-1:0] offset_to_twos(input logic [W-1:0] v);
    return v ^ TOP_BIT;
  endfunction

  logic [W-1:0] trial_q;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n or posedge clr_i) begin
    if (!rst_n) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (clr_i) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (load_i) begin
      trial_q <= TOP_BIT;
      mask_q  <= TOP_BIT;
    end else if (step_i) begin
      trial_q <= resolve_bit(trial_q, mask_q, too_high_i);
      mask_q  <= mask_q >> 1;
    end
  end

  assign trial_o = trial_q;
  assign code_o  = offset_to_twos(trial_q);

  // R2: at most one bit is under test at a time
  p_mask_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    $onehot0(mask_q));

  // R2: a step never disturbs bits already decided above the tested one
  p_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (step_i && !load_i) |=>
      ((trial_q & ~(($past(mask_q) << 1) - 1'b1)) ==
       ($past(trial_q) & ~(($past(mask_q) << 1) - 1'b1))));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int W             = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int CAL_CYCLES    = 85530
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_i,
  input  logic       clk_lvl_i,
  input  logic       smp_lvl_i,
  input  logic       cal_lvl_i,
  output logic       busy_o,
  output logic       load_o,
  output logic       step_o,
  output logic       latch_o,
  output logic       settle_o,
  output logic       diag_en_o,
  output logic [1:0] diag_o
);

  localparam int CONV_EDGES = W + 1;
  localparam int EDGE_W     = $clog2(CONV_EDGES + 1);
  localparam int SET_W      = $clog2(SETTLE_CYCLES + 1);
  localparam int CAL_W      = $clog2(CAL_CYCLES + 1);

  seq_state_e        state_q;
  logic [EDGE_W-1:0] edge_q;
  logic [SET_W-1:0]  settle_q;
  logic [CAL_W-1:0]  cal_q;
  logic              tail_q;
  logic              clk_prev_q;
  logic              smp_prev_q;
  logic              cal_prev_q;

  logic clk_rise;
  logic smp_fall;
  logic cal_fall;
  logic conv_edge;
  logic last_edge;

  // Edge detection after synchronisation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      smp_prev_q <= 1'b0;
    end else begin
      clk_prev_q <= clk_lvl_i;
      smp_prev_q <= smp_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge cal_i) begin
    if (!rst_n)     cal_prev_q <= 1'b0;
    else if (cal_i) cal_prev_q <= 1'b1;
    else            cal_prev_q <= cal_lvl_i;
  end

  assign clk_rise  = clk_lvl_i & ~clk_prev_q;
  assign smp_fall  = ~smp_lvl_i & smp_prev_q;
  assign cal_fall  = ~cal_lvl_i & cal_prev_q;
  assign conv_edge = (state_q == ST_CONV) && clk_rise && !tail_q;
  assign last_edge = (edge_q == EDGE_W'(W));

  always_ff @(posedge clk or negedge rst_n or posedge cal_i) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      edge_q   <= '0;
      settle_q <= '0;
      cal_q    <= '0;
      tail_q   <= 1'b0;
    end else if (cal_i) begin
      state_q  <= ST_CALHOLD;
      edge_q   <= '0;
      settle_q <= '0;
      cal_q    <= '0;
      tail_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (clk_rise && tail_q) tail_q <= 1'b0;
          if (smp_fall) begin
            state_q  <= ST_SETTLE;
            settle_q <= '0;
            edge_q   <= '0;
          end
        end
        ST_SETTLE: begin
          if (settle_q == SET_W'(SETTLE_CYCLES - 1)) state_q <= ST_CONV;
          else settle_q <= settle_q + 1'b1;
        end
        ST_CONV: begin
          if (clk_rise) begin
            if (tail_q) begin
              tail_q <= 1'b0;
            end else if (last_edge) begin
              state_q <= ST_IDLE;
              edge_q  <= '0;
            end else begin
              edge_q <= edge_q + 1'b1;
            end
          end
        end
        ST_CALHOLD: begin
          if (cal_fall || !cal_lvl_i) state_q <= ST_CAL;
        end
        ST_CAL: begin
          if (clk_rise) begin
            cal_q <= cal_q + 1'b1;
            if (cal_q == CAL_W'(CAL_CYCLES - 1)) begin
              state_q <= ST_IDLE;
              tail_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign load_o    = (state_q == ST_IDLE) && smp_fall;
  assign step_o    = conv_edge && !last_edge;
  assign latch_o   = conv_edge && last_edge;
  assign settle_o  = (state_q == ST_SETTLE);
  assign diag_en_o = ((state_q == ST_CAL) || (state_q == ST_CALHOLD)) && smp_lvl_i;
  assign diag_o    = cal_q[1:0];

  // R1: a commit while idle raises busy on the next cycle
  p_commit_busy_r1: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    ((state_q == ST_IDLE) && smp_fall) |=> busy_o);

  // R4: publishing the code drops busy
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    latch_o |=> !busy_o);

  // R6: a sampling fall during a conversion does not restart it
  p_sample_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    ((state_q == ST_CONV) && smp_fall && !clk_rise) |=> (state_q == ST_CONV));

  // R9: calibration count never passes its limit
  p_cal_bound_r9: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    (cal_q <= CAL_W'(CAL_CYCLES)));

  // R10: the owed tail edge does not advance the conversion count
  p_tail_eats_edge_r10: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    ((state_q == ST_CONV) && clk_rise && tail_q) |=> $stable(edge_q));

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         latch_i,
  input  logic [W-1:0] code_i,
  input  logic         diag_en_i,
  input  logic [1:0]   diag_i,
  output logic [W-1:0] data_o
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n or posedge clr_i) begin
    if (!rst_n)       held_q <= '0;
    else if (clr_i)   held_q <= '0;
    else if (latch_i) held_q <= code_i;
  end

  assign data_o = {held_q[W-1:2], diag_en_i ? diag_i : held_q[1:0]};

  // R5: the latch only moves on a publish event
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    !latch_i |=> $stable(held_q));

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int W             = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int CAL_CYCLES    = 85530,
  parameter int SYNC_STAGES   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnv_clk_i,
  input  logic         sample_i,
  input  logic         cal_i,
  input  logic         cmp_hi_i,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic [W-1:0] result_o
);

  logic         clk_lvl;
  logic         smp_lvl;
  logic         cal_lvl;
  logic         load;
  logic         step;
  logic         latch;
  logic         in_settle;
  logic         diag_en;
  logic [1:0]   diag;
  logic [W-1:0] code;

  sar_sync #(.STAGES(SYNC_STAGES), .ASYNC_SET(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .set_i(1'b0), .d_i(cnv_clk_i), .lvl_o(clk_lvl));

  sar_sync #(.STAGES(SYNC_STAGES), .ASYNC_SET(1'b0)) u_sync_smp (
    .clk(clk), .rst_n(rst_n), .set_i(1'b0), .d_i(sample_i), .lvl_o(smp_lvl));

  sar_sync #(.STAGES(SYNC_STAGES), .ASYNC_SET(1'b1)) u_sync_cal (
    .clk(clk), .rst_n(rst_n), .set_i(cal_i), .d_i(cal_i), .lvl_o(cal_lvl));

  sar_seq_ctrl #(.W(W), .SETTLE_CYCLES(SETTLE_CYCLES), .CAL_CYCLES(CAL_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_i(cal_i),
    .clk_lvl_i(clk_lvl), .smp_lvl_i(smp_lvl), .cal_lvl_i(cal_lvl),
    .busy_o(busy_o), .load_o(load), .step_o(step), .latch_o(latch),
    .settle_o(in_settle), .diag_en_o(diag_en), .diag_o(diag));

  sar_approx #(.W(W)) u_approx (
    .clk(clk), .rst_n(rst_n), .clr_i(cal_i), .load_i(load), .step_i(step),
    .too_high_i(cmp_hi_i), .trial_o(trial_o), .code_o(code));

  sar_out_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(cal_i), .latch_i(latch), .code_i(code),
    .diag_en_i(diag_en), .diag_i(diag), .data_o(result_o));

  // R3: the trial code is frozen across the settling window
  p_settle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    in_settle |=> $stable(trial_o));

  // R8: while calibration is requested the block reports busy
  p_cal_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_i |-> busy_o);

endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;

  localparam int W      = 16;
  localparam int SETTLE = 8;
  localparam int CALN   = 20;
  localparam int NV     = 11;

  localparam int VIN_TAB [NV] = '{0, 1, -1, 32767, -32768, 40000, -50000,
                                  12345, -12345, 21845, -10922};
  localparam logic [15:0] EXP_TAB [NV] = '{16'h0000, 16'h0001, 16'hFFFF,
                                           16'h7FFF, 16'h8000, 16'h7FFF,
                                           16'h8000, 16'h3039, 16'hCFC7,
                                           16'h5555, 16'hD556};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv_clk = 1'b0;
  logic         sample = 1'b0;
  logic         cal = 1'b0;
  logic         cmp_hi;
  logic [W-1:0] trial;
  logic         busy;
  logic [W-1:0] result;
  int           vin = 0;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  // Analog model: the trial is too high when its signed value exceeds the input.
  assign cmp_hi = (int'(trial) - 32768) > vin;

  sar_seq_top #(.W(W), .SETTLE_CYCLES(SETTLE), .CAL_CYCLES(CALN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_clk_i(cnv_clk), .sample_i(sample),
    .cal_i(cal), .cmp_hi_i(cmp_hi), .trial_o(trial), .busy_o(busy),
    .result_o(result));

  function automatic logic [15:0] clamp_code(input int v);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    cnv_clk = 1'b1; cyc(4);
    cnv_clk = 1'b0; cyc(4);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  // Acquire then commit; also checks R1 timing of busy.
  task automatic start_conv(input int v);
    vin = v;
    sample = 1'b1; cyc(6);
    sample = 1'b0; cyc(1);
    chk("R1 busy before commit", busy, 1'b0);
    cyc(3);
    chk("R1 busy after commit", busy, 1'b1);
    cyc(10);
  endtask

  task automatic finish_conv(input int v, input string tag);
    pulses(16);
    chk({tag, " busy after 16 edges"}, busy, 1'b1);
    pulse();
    chk({tag, " busy after 17th edge"}, busy, 1'b0);
    chk({tag, " result"}, result, clamp_code(v));
  endtask

  initial begin
    logic [15:0] prev;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R13 reset busy", busy, 1'b0);
    chk("R13 reset result", result, 16'h0000);
    chk("R13 reset trial", trial, 16'h0000);

    // R2, R12: table of input values
    for (int k = 0; k < NV; k++) begin
      start_conv(VIN_TAB[k]);
      if (k == 0) chk("R2 first trial code", trial, 16'h8000);
      pulses(16);
      chk("R4 busy held until 17th edge", busy, 1'b1);
      pulse();
      chk("R4 busy low after 17th edge", busy, 1'b0);
      chk("R2 R12 table result", result, EXP_TAB[k]);
    end

    // R3: an early clock edge inside the settling window is discarded
    vin = 1000;
    sample = 1'b1; cyc(6);
    sample = 1'b0; cyc(1);
    cnv_clk = 1'b1; cyc(2); cnv_clk = 1'b0;
    cyc(14);
    chk("R3 trial untouched by early edge", trial, 16'h8000);
    finish_conv(1000, "R3");

    // R5: previous code stays until 17th edge of next conversion
    prev = result;
    start_conv(-2000);
    pulses(16);
    chk("R5 result held during conversion", result, prev);
    pulse();
    chk("R5 result updated", result, clamp_code(-2000));

    // R6: sampling edges during busy are ignored; R4 later edges ignored
    start_conv(300);
    pulses(5);
    sample = 1'b1; cyc(4); sample = 1'b0; cyc(4);
    sample = 1'b1; cyc(4); sample = 1'b0; cyc(4);
    pulses(11);
    chk("R6 busy still high", busy, 1'b1);
    pulse();
    chk("R6 busy low", busy, 1'b0);
    chk("R6 result", result, clamp_code(300));
    pulses(3);
    cyc(20);
    chk("R6 no new conversion", busy, 1'b0);
    chk("R4 result unchanged after extra edges", result, clamp_code(300));

    // R7: back-to-back conversion
    start_conv(-77);
    pulses(16);
    sample = 1'b1; cyc(2);
    pulse();
    chk("R7 first busy low", busy, 1'b0);
    chk("R7 first result", result, clamp_code(-77));
    vin = 4242;
    cyc(2);
    sample = 1'b0; cyc(4);
    chk("R7 second commit busy", busy, 1'b1);
    cyc(10);
    finish_conv(4242, "R7");

    // R8: asynchronous calibration request; R11 diagnostics; R9 length
    cal = 1'b1; #1;
    chk("R8 busy async", busy, 1'b1);
    chk("R8 result cleared async", result, 16'h0000);
    cyc(4);
    cal = 1'b0; cyc(6);
    sample = 1'b1; cyc(4);
    pulses(6);
    chk("R11 diag bits", result, 16'h0002);
    sample = 1'b0; cyc(4);
    chk("R11 diag gone with sample low", result, 16'h0000);
    pulses(13);
    chk("R9 busy before last cal edge", busy, 1'b1);
    pulse();
    chk("R9 busy after cal", busy, 1'b0);

    // R10: tail edge missing, next conversion takes 18 edges
    start_conv(777);
    pulses(17);
    chk("R10 busy after 17 edges with tail owed", busy, 1'b1);
    pulse();
    chk("R10 busy after 18 edges", busy, 1'b0);
    chk("R10 result", result, clamp_code(777));

    // R8: abort a conversion, recalibrate with tail supplied
    start_conv(100);
    pulses(5);
    cal = 1'b1; #1;
    chk("R8 abort busy", busy, 1'b1);
    cyc(4);
    cal = 1'b0; cyc(6);
    pulses(CALN);
    chk("R9 second cal end", busy, 1'b0);
    chk("R8 aborted conversion not published", result, 16'h0000);
    pulse();
    start_conv(-3);
    finish_conv(-3, "R10 tail supplied");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule